// File: doc/BRIEF.md
# CEC Transmit Retry Controller

This block owns one outgoing consumer-electronics-control frame from the moment software arms it until a single terminal outcome is reported. Software loads up to sixteen frame bytes, a byte count and a retry limit through a narrow write port, then sets the enable bit. The block then asks an external line engine for one attempt at a time. Each attempt ends with one of four outcomes. The block decides whether to try again, stop, or give up.

The line engine reads frame bytes by index and sees the valid byte count on dedicated outputs. Every request ends with exactly one of three sticky flags: success, lost arbitration, or retries exhausted. Negative acknowledges and low-drive errors are each counted per request, and the two counts are packed into one byte. The busy output serves as the read-back of the enable bit.

Top module: `cec_tx_retry_ctrl`

## Requirements
- R1: After reset, tx_busy, att_req, irq_flags and fail_cnt are all zero.
- R2: Writing a value with bit 0 set to address 0x12 while idle starts a request. tx_busy reads 1 until the request ends. Writing 0x12 with bit 0 clear starts nothing.
- R3: Addresses 0x00 to 0x0F hold frame bytes 0 to 15, and byte_data returns the byte selected by byte_idx. Address 0x10 holds the byte count. A written count above 16 is stored as 16, and att_len always shows the stored count.
- R4: Bits 6:4 written to address 0x11 set the retry limit N, so a request makes at most N+1 attempts. When every attempt fails with a nack or a low-drive error, irq_flags bit 2 (retries exhausted) is raised.
- R5: An attempt outcome of ack (res_code 0) raises irq_flags bit 0 at once, and no further attempt is made.
- R6: An outcome of arbitration lost (res_code 2) ends the request at once without a retry. It raises only irq_flags bit 1 and leaves fail_cnt unchanged.
- R7: fail_cnt bits 3:0 count nack outcomes (res_code 1) and bits 7:4 count low-drive outcomes (res_code 3) within the current request. Each count saturates at 15.
- R8: Both counts return to zero when a new request starts.
- R9: Each request raises exactly one of the three flags, in the same clock edge where tx_busy falls.
- R10: A request started with a byte count of 0 makes no attempt. It ends one cycle after start with flag bit 2 set and fail_cnt at zero.
- R11: Writing ones to bits 2:0 of address 0x13 clears the matching flags, and other flags are kept. If a flag is raised in the same cycle as its clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| byte_idx | input | 4 | Frame byte index selected by the line engine |
| byte_data | output | 8 | Frame byte at byte_idx |
| att_len | output | 5 | Stored frame byte count |
| att_req | output | 1 | An attempt is requested and awaiting its outcome |
| res_valid | input | 1 | Attempt outcome strobe |
| res_code | input | 2 | Outcome: 0 ack, 1 nack, 2 arbitration lost, 3 low drive |
| tx_busy | output | 1 | Request in progress (enable read-back) |
| irq_flags | output | 3 | Sticky flags: bit 0 success, bit 1 arbitration lost, bit 2 retries exhausted |
| fail_cnt | output | 8 | Low-drive count in bits 7:4, nack count in bits 3:0 |

## Verification
The terminal raising of a flag and a software clear of that same flag can happen in the same cycle. A clear written just before the next request can meet a late outcome. The bench provokes this by driving the last attempt's ack outcome and a clear-all write to 0x13 on the same clock edge. It then judges the result through the scoreboard, which expects the success flag to be set after the edge. A second case clears only the flags that are not raised, then checks that the raised flag survives.

// File: rtl/cec_tx_pkg.sv
// Package: shared encodings for the CEC transmit retry controller.
// Assumes: the outcome encoding matches the line engine's res_code.
package cec_tx_pkg;
    typedef enum logic [1:0] {
        RES_ACK    = 2'd0,
        RES_NACK   = 2'd1,
        RES_ARB    = 2'd2,
        RES_LOWDRV = 2'd3
    } res_code_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LAUNCH  = 2'd1,
        ST_ATTEMPT = 2'd2
    } seq_state_e;

    localparam int unsigned FLAG_OK  = 0;
    localparam int unsigned FLAG_ARB = 1;
    localparam int unsigned FLAG_TMO = 2;
    localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/cec_tx_regs.sv
// Module: register store for the frame bytes, byte count and retry limit.
// Decodes the enable write and the flag-clear write into strobes.
// Assumes: one write per cycle, and register addresses placed just above the buffer.
module cec_tx_regs #(
    parameter int BUF_DEPTH = 16,
    parameter int RETRY_W   = 3,
    parameter int NUM_FLAGS = 3,
    localparam int IDX_W    = $clog2(BUF_DEPTH),
    localparam int LEN_W    = IDX_W + 1,
    localparam int ADDR_W   = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           rd_byte,
    output logic [LEN_W-1:0]     frame_len,
    output logic [RETRY_W-1:0]   retry_lim,
    output logic                 en_wr,
    output logic [NUM_FLAGS-1:0] clr_wr
);
    localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(BUF_DEPTH);
    localparam logic [ADDR_W-1:0] A_RETRY = ADDR_W'(BUF_DEPTH + 1);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(BUF_DEPTH + 2);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(BUF_DEPTH + 3);
    localparam int RETRY_LSB = 4;

    logic [7:0] buf_q [BUF_DEPTH];

    genvar g;
    generate
        for (g = 0; g < BUF_DEPTH; g++) begin : g_byte
            // Capture one frame byte on a write to its address.
            always_ff @(posedge clk) begin
                if (!rst_n) buf_q[g] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g)) buf_q[g] <= wr_data;
            end
        end
    endgenerate

    // Byte read port for the line engine.
    assign rd_byte = buf_q[rd_idx];

    // Store the byte count, clamped to the buffer depth.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_len <= '0;
        else if (wr_en && wr_addr == A_LEN) begin
            if (int'(wr_data) > BUF_DEPTH) frame_len <= LEN_W'(BUF_DEPTH);
            else                           frame_len <= wr_data[LEN_W-1:0];
        end
    end

    // Store the retry limit field.
    always_ff @(posedge clk) begin
        if (!rst_n) retry_lim <= '0;
        else if (wr_en && wr_addr == A_RETRY) retry_lim <= wr_data[RETRY_LSB +: RETRY_W];
    end

    // Decode the start and clear strobes.
    always_comb begin
        en_wr  = wr_en && (wr_addr == A_EN) && wr_data[0];
        clr_wr = (wr_en && wr_addr == A_CLR) ? wr_data[NUM_FLAGS-1:0] : '0;
    end

    // R3
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_LEN) |=> (int'(frame_len) <= BUF_DEPTH));
endmodule

// File: rtl/cec_tx_seq.sv
// Module: attempt sequencer. It issues attempts, counts failures and
// decides the terminal outcome of each request.
// Assumes: res_valid is only meaningful while att_req is high.
module cec_tx_seq
    import cec_tx_pkg::*;
#(
    parameter int RETRY_W = 3,
    parameter int CNT_W   = 4,
    parameter int LEN_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [LEN_W-1:0]     frame_len,
    input  logic [RETRY_W-1:0]   retry_lim,
    input  logic                 res_valid,
    input  logic [1:0]           res_code,
    output logic                 att_req,
    output logic                 busy,
    output logic [NUM_FLAGS-1:0] term,
    output logic [2*CNT_W-1:0]   fail_cnt
);
    seq_state_e       st_q;
    logic [RETRY_W-1:0] left_q;
    logic [CNT_W-1:0] nack_q;
    logic [CNT_W-1:0] lowd_q;
    res_code_e        code;
    logic             accept;
    logic             fail_now;
    logic             arm;

    // Classify the incoming outcome.
    always_comb begin
        code     = res_code_e'(res_code);
        accept   = (st_q == ST_ATTEMPT) && res_valid;
        fail_now = accept && (code == RES_NACK || code == RES_LOWDRV);
        arm      = (st_q == ST_IDLE) && start;
    end

    // Pick the terminal flag, if any, for this cycle.
    always_comb begin
        term = '0;
        if (st_q == ST_LAUNCH && frame_len == '0) term[FLAG_TMO] = 1'b1;
        if (accept) begin
            case (code)
                RES_ACK: term[FLAG_OK]  = 1'b1;
                RES_ARB: term[FLAG_ARB] = 1'b1;
                default: if (left_q == '0) term[FLAG_TMO] = 1'b1;
            endcase
        end
    end

    // Request state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else begin
            case (st_q)
                ST_IDLE:    if (start) st_q <= ST_LAUNCH;
                ST_LAUNCH:  st_q <= (frame_len == '0) ? ST_IDLE : ST_ATTEMPT;
                ST_ATTEMPT: if (res_valid) st_q <= (|term) ? ST_IDLE : ST_LAUNCH;
                default:    st_q <= ST_IDLE;
            endcase
        end
    end

    // Remaining retries: loaded at start, spent on each failed attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else if (arm) left_q <= retry_lim;
        else if (fail_now && left_q != '0) left_q <= left_q - 1'b1;
    end

    // Saturating failure counters, cleared at start.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            nack_q <= '0;
            lowd_q <= '0;
        end else if (fail_now) begin
            if (code == RES_NACK && nack_q != '1)   nack_q <= nack_q + 1'b1;
            if (code == RES_LOWDRV && lowd_q != '1) lowd_q <= lowd_q + 1'b1;
        end
    end

    assign att_req  = (st_q == ST_ATTEMPT);
    assign busy     = (st_q != ST_IDLE);
    assign fail_cnt = {lowd_q, nack_q};

    // R9
    term_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(term));

    // R6
    arb_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && code == RES_ARB) |=> (!busy && $stable(fail_cnt)));

    // R5
    ack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && code == RES_ACK) |=> (!busy && !att_req));

    // R7
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (nack_q >= $past(nack_q) && lowd_q >= $past(lowd_q)));

    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LAUNCH && frame_len == '0) |=> (!busy && fail_cnt == '0));
endmodule

// File: rtl/cec_tx_irq.sv
// Module: sticky completion flags, set by terminal events and cleared by write-one.
// Assumes: a set and a clear in the same cycle resolve to set.
module cec_tx_irq #(
    parameter int NUM_FLAGS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic [NUM_FLAGS-1:0] clr_i,
    output logic [NUM_FLAGS-1:0] flags
);
    // Hold each flag until cleared; a raise in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_i) | set_i;
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags & $past(set_i)) == $past(set_i)));

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(clr_i) & $past(flags)) == ($past(flags) & ~$past(clr_i))));
endmodule

// File: rtl/cec_tx_retry_ctrl.sv
// Module: top of the CEC transmit retry controller. It ties together the
// register store, the attempt sequencer and the sticky flags.
// Assumes: the line engine answers each attempt request with one outcome strobe.
module cec_tx_retry_ctrl
    import cec_tx_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int RETRY_W   = 3,
    parameter int CNT_W     = 4,
    localparam int IDX_W    = $clog2(BUF_DEPTH),
    localparam int LEN_W    = IDX_W + 1,
    localparam int ADDR_W   = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [IDX_W-1:0]     byte_idx,
    output logic [7:0]           byte_data,
    output logic [LEN_W-1:0]     att_len,
    output logic                 att_req,
    input  logic                 res_valid,
    input  logic [1:0]           res_code,
    output logic                 tx_busy,
    output logic [NUM_FLAGS-1:0] irq_flags,
    output logic [2*CNT_W-1:0]   fail_cnt
);
    logic [RETRY_W-1:0]   retry_lim;
    logic                 en_wr;
    logic [NUM_FLAGS-1:0] clr_wr;
    logic [NUM_FLAGS-1:0] term;

    cec_tx_regs #(.BUF_DEPTH(BUF_DEPTH), .RETRY_W(RETRY_W), .NUM_FLAGS(NUM_FLAGS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(byte_idx), .rd_byte(byte_data), .frame_len(att_len),
        .retry_lim(retry_lim), .en_wr(en_wr), .clr_wr(clr_wr)
    );

    cec_tx_seq #(.RETRY_W(RETRY_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(en_wr), .frame_len(att_len),
        .retry_lim(retry_lim), .res_valid(res_valid), .res_code(res_code),
        .att_req(att_req), .busy(tx_busy), .term(term), .fail_cnt(fail_cnt)
    );

    cec_tx_irq #(.NUM_FLAGS(NUM_FLAGS)) irq_i (
        .clk(clk), .rst_n(rst_n), .set_i(term), .clr_i(clr_wr), .flags(irq_flags)
    );

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !tx_busy) |=> tx_busy);
endmodule

// File: tb/cec_tx_retry_ctrl_tb.sv
module cec_tx_retry_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] byte_idx = '0;
    logic [7:0] byte_data;
    logic [4:0] att_len;
    logic       att_req;
    logic       res_valid = 1'b0;
    logic [1:0] res_code = '0;
    logic       tx_busy;
    logic [2:0] irq_flags;
    logic [7:0] fail_cnt;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [2:0] flags;
        logic [7:0] cnt;
        int         atts;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    cec_tx_retry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .byte_idx(byte_idx), .byte_data(byte_data), .att_len(att_len), .att_req(att_req),
        .res_valid(res_valid), .res_code(res_code), .tx_busy(tx_busy),
        .irq_flags(irq_flags), .fail_cnt(fail_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: programs a request, queues its expected outcome, answers attempts.
    task automatic run_req(input int len, input int rty, input logic [15:0] codes,
                           input bit clr_last, input logic [2:0] ef,
                           input logic [7:0] ec, input int ea, input string tag);
        exp_t e;
        int k = 0;
        wr(5'h10, 8'(len));
        wr(5'h11, 8'(rty << 4));
        wr(5'h13, 8'h07);
        e.flags = ef; e.cnt = ec; e.atts = ea; e.tag = tag;
        sb_q.push_back(e);
        wr(5'h12, 8'h01);
        forever begin
            @(negedge clk);
            wr_en = 1'b0;
            if (!tx_busy) break;
            if (att_req && !res_valid) begin
                res_valid = 1'b1;
                res_code  = codes[2*k +: 2];
                k++;
                if (clr_last) begin
                    wr_en = 1'b1; wr_addr = 5'h13; wr_data = 8'h07;
                end
            end else begin
                res_valid = 1'b0;
            end
        end
        res_valid = 1'b0;
    endtask

    // Monitor: on each busy fall, pop and compare the expected outcome.
    int   att_seen = 0;
    logic busy_prev = 1'b0;
    logic att_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            att_seen = 0; busy_prev = 1'b0; att_prev = 1'b0;
        end else begin
            if (att_req && !att_prev) att_seen++;
            if (busy_prev && !tx_busy) begin
                if (sb_q.size() == 0) chk("R9 unexpected completion", 1, 0);
                else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk({e.tag, " flags"}, int'(irq_flags), int'(e.flags));
                    chk({e.tag, " R7 fail_cnt"}, int'(fail_cnt), int'(e.cnt));
                    chk({e.tag, " R4 attempts"}, att_seen, e.atts);
                end
                att_seen = 0;
            end
            busy_prev = tx_busy;
            att_prev  = att_req;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(tx_busy), 0);
        chk("R1 att_req", int'(att_req), 0);
        chk("R1 flags", int'(irq_flags), 0);
        chk("R1 fail_cnt", int'(fail_cnt), 0);

        // R3 frame bytes and count
        for (int i = 0; i < 16; i++) wr(5'(i), 8'(8'hA0 + i));
        byte_idx = 4'd0; #1 chk("R3 byte 0", int'(byte_data), 8'hA0);
        byte_idx = 4'd15; #1 chk("R3 byte 15", int'(byte_data), 8'hAF);
        wr(5'h10, 8'd20);
        chk("R3 len clamp", int'(att_len), 16);
        wr(5'h10, 8'd5);
        chk("R3 len", int'(att_len), 5);

        // R2 enable with bit 0 clear starts nothing
        wr(5'h12, 8'h00);
        chk("R2 no start", int'(tx_busy), 0);

        // Codes: 0 ack, 1 nack, 2 arb, 3 low drive
        run_req(4, 0, 16'h0000, 1'b0, 3'b001, 8'h00, 1, "R5 ack first");
        run_req(4, 3, {10'd0, 2'd0, 2'd3, 2'd1}, 1'b0, 3'b001, 8'h11, 3, "R5 ack after retries");
        run_req(4, 2, {10'd0, 2'd1, 2'd3, 2'd1}, 1'b0, 3'b100, 8'h12, 3, "R4 exhausted");
        repeat (2) @(negedge clk);
        wr(5'h13, 8'h03);
        chk("R11 clear others keeps flag", int'(irq_flags), 3'b100);
        wr(5'h13, 8'h04);
        chk("R11 clear flag", int'(irq_flags), 3'b000);
        run_req(4, 7, 16'h5555, 1'b0, 3'b100, 8'h08, 8, "R4 eight attempts");
        run_req(4, 3, {12'd0, 2'd2, 2'd1}, 1'b0, 3'b010, 8'h01, 2, "R6 arb");
        run_req(4, 1, 16'h0000, 1'b0, 3'b001, 8'h00, 1, "R8 counters cleared");
        run_req(0, 3, 16'h0000, 1'b0, 3'b100, 8'h00, 0, "R10 zero length");
        run_req(4, 0, 16'h0000, 1'b1, 3'b001, 8'h00, 1, "R11 set wins over clear");

        repeat (4) @(negedge clk);
        chk("R9 all completions seen", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule